// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block owns the state array of a small write-back data cache (valid bit, dirty bit, tag and line data for every line) and carries out the maintenance commands that software issues through a coprocessor-style register. The supported commands are: dropping every line at once; dropping a single line; writing back a single line; writing back and then dropping a single line; and two incremental scan commands that software polls until the whole cache is clean.

A single-line command picks its line in one of two ways. It can name a set and a way directly, or it can give a byte address that is looked up against the tags. Any line that has to go back to memory is placed on a write-back port as a line address and the full line data. That request is held until memory acknowledges it, and no new command is accepted in the meantime. The scan commands are reads. Each one writes back no more than one dirty line per call and returns a status word whose bit 30 says whether a dirty line was still present. The scan-and-drop variant also clears the whole cache on the first call that finds nothing dirty.

A fill port stands in for the load/store path and installs lines. A combinational probe port reports whether an address hits and whether that line is dirty.

Top module: `dcache_maint`

## Requirements
- R1: After reset no line is valid, `cmd_ready` is 1, and both `wb_req` and `rd_valid` are 0.
- R2: A write with opcode 0 (drop all) clears the valid bit of every line and issues no write-back, whether or not lines are dirty.
- R3: A write with opcode 1 (drop line) makes the selected line invalid and issues no write-back. Other lines are not changed.
- R4: A write with opcode 2 (clean line) issues a write-back only when the selected line is valid and dirty. The write-back carries address {tag, set, 5'b0} and the line's data. The line then stays valid and is no longer dirty.
- R5: A write with opcode 3 (clean and drop line) issues a write-back only when the line is valid and dirty, and in every case leaves the line invalid.
- R6: When `cmd_by_addr` is 1, a single-line command selects the line whose tag matches `cmd_addr[31:9]` in set `cmd_addr[8:5]`, and the result is the same as selecting that set and way by index. An address that misses changes nothing and issues no write-back.
- R7: `wb_req` rises in the cycle after an accepted command and stays high, with address and data stable, until the first cycle in which `wb_ack` is sampled high. `cmd_ready` is low for that whole time.
- R8: A read with opcode 4 (scan-clean) returns `rd_data` = 32'h4000_0000 if any valid dirty line exists and 0 otherwise. If one exists, it writes back the valid dirty line with the lowest flat index set*4+way and clears that line's dirty bit.
- R9: A read with opcode 5 (scan-clean-drop) behaves like opcode 4. When it finds no dirty line it returns 0 and makes every line invalid.
- R10: `rd_valid` pulses for one cycle after every accepted read. A read with any opcode other than 4 or 5 returns 0. A write with opcode 4 or 5 changes nothing and issues no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (no write-back pending) |
| cmd_read | input | 1 | 1 = register read (scan commands), 0 = write |
| cmd_op | input | 3 | Opcode 0..5 |
| cmd_by_addr | input | 1 | 1 = select the line by address lookup |
| cmd_set | input | 4 | Set index for index selection |
| cmd_way | input | 2 | Way index for index selection |
| cmd_addr | input | 32 | Byte address for address selection |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result, bit 30 = dirty status |
| wb_req | output | 1 | Write-back request pending |
| wb_addr | output | 32 | Write-back line address |
| wb_data | output | 256 | Write-back line data |
| wb_ack | input | 1 | Memory accepts the write-back |
| fill_en | input | 1 | Install a line |
| fill_set | input | 4 | Fill set |
| fill_way | input | 2 | Fill way |
| fill_tag | input | 23 | Fill tag |
| fill_dirty | input | 1 | Installed line is dirty |
| fill_data | input | 256 | Installed line data |
| probe_addr | input | 32 | Address to look up |
| probe_hit | output | 1 | Probe address is valid in the cache |
| probe_dirty | output | 1 | Probed line is dirty |

## Verification
The scan commands are driven with dirty lines placed out of index order. A design that picked the wrong line, cleaned more than one line per call, or reported bit 30 from the state after the clean would return a wrong status or send write-backs in the wrong order. Clean and clean-and-drop are also issued on lines that are already clean, so a design that ignored the dirty bit would emit a spurious write-back. An address lookup that misses in an occupied set, as well as write-back stalls held across several cycles, exposes engines that act on the wrong way or drop a pending request. Reserved reads, and writes that carry a scan opcode, confirm that no state is touched.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    OP_DROP_ALL  = 3'd0,
    OP_DROP_LINE = 3'd1,
    OP_CLEAN     = 3'd2,
    OP_CLEAN_DROP = 3'd3,
    OP_SCAN      = 3'd4,
    OP_SCAN_DROP = 3'd5
  } maint_op_e;

  localparam int STATUS_DIRTY_BIT = 30;
endpackage

// File: rtl/dcm_lookup.sv
module dcm_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            match,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_valid[w] && (row_tag[w] == key);
  end

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/dcm_scan.sv
module dcm_scan #(
  parameter int LINES = 64,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  dirty_vec,
  output logic              found,
  output logic [LINE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (dirty_vec[i]) idx = LINE_W'(i);
    end
  end

  assign found = |dirty_vec;

  // R8
  scan_pick_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> dirty_vec[idx]);

  // R8
  scan_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((dirty_vec & ((LINES'(1) << idx) - LINES'(1))) == '0));
endmodule

// File: rtl/dcm_wb_port.sv
module dcm_wb_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic req_d;
  logic load_en;

  always_comb begin
    req_d   = req;
    load_en = 1'b0;
    if (start) begin
      req_d   = 1'b1;
      load_en = 1'b1;
    end else if (ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr <= start_addr;
      data <= start_data;
    end
  end

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(data)));
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS * WORD_W / 8),
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int LINE_B = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_by_addr,
  input  logic [SET_W-1:0]  cmd_set,
  input  logic [WAY_W-1:0]  cmd_way,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_B-1:0] wb_data,
  input  logic              wb_ack,
  input  logic              fill_en,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_dirty,
  input  logic [LINE_B-1:0] fill_data,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_dirty
);
  localparam int LINES  = WAYS * SETS;
  localparam int LINE_W = SET_W + WAY_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // line state
  logic [LINES-1:0]  valid_q, valid_d;
  logic [LINES-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_B-1:0] data_q [LINES];

  maint_op_e op;
  logic      cmd_fire;
  assign op        = maint_op_e'(cmd_op);
  assign cmd_ready = !wb_req;
  assign cmd_fire  = cmd_valid && cmd_ready;

  // per-set rows for the two lookups
  logic [SET_W-1:0]            cset, pset;
  logic [WAYS-1:0]             c_vrow, p_vrow;
  logic [WAYS-1:0][TAG_W-1:0]  c_trow, p_trow;
  assign cset = cmd_addr[OFF_W +: SET_W];
  assign pset = probe_addr[OFF_W +: SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign c_vrow[w] = valid_q[{cset, WAY_W'(w)}];
    assign c_trow[w] = tag_q[{cset, WAY_W'(w)}];
    assign p_vrow[w] = valid_q[{pset, WAY_W'(w)}];
    assign p_trow[w] = tag_q[{pset, WAY_W'(w)}];
  end

  logic [WAYS-1:0]  c_match, p_match;
  logic             c_hit, p_hit;
  logic [WAY_W-1:0] c_way, p_way;

  dcm_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmd_lookup (
    .row_valid(c_vrow), .row_tag(c_trow), .key(cmd_addr[ADDR_W-1 -: TAG_W]),
    .match(c_match), .hit(c_hit), .way(c_way));

  dcm_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_probe_lookup (
    .row_valid(p_vrow), .row_tag(p_trow), .key(probe_addr[ADDR_W-1 -: TAG_W]),
    .match(p_match), .hit(p_hit), .way(p_way));

  assign probe_hit   = p_hit;
  assign probe_dirty = p_hit && dirty_q[{pset, p_way}];

  // scan for the lowest valid dirty line
  logic              scan_found;
  logic [LINE_W-1:0] scan_idx;
  dcm_scan #(.LINES(LINES)) u_scan (
    .clk(clk), .rst_n(rst_i_n), .dirty_vec(valid_q & dirty_q),
    .found(scan_found), .idx(scan_idx));

  // selected line for single-line commands
  logic [LINE_W-1:0] sel_line;
  logic              sel_ok;
  always_comb begin
    if (cmd_by_addr) begin
      sel_line = {cset, c_way};
      sel_ok   = c_hit;
    end else begin
      sel_line = {cmd_set, cmd_way};
      sel_ok   = 1'b1;
    end
  end

  // next-state logic
  logic              wb_start;
  logic [LINE_W-1:0] wb_line;
  logic              rd_valid_d;
  logic [31:0]       rd_data_d;
  logic              fill_wr_en;
  logic [LINE_W-1:0] fill_line;
  assign fill_line  = {fill_set, fill_way};
  assign fill_wr_en = fill_en;

  always_comb begin
    valid_d    = valid_q;
    dirty_d    = dirty_q;
    wb_start   = 1'b0;
    wb_line    = sel_line;
    rd_valid_d = 1'b0;
    rd_data_d  = '0;
    if (cmd_fire && !cmd_read) begin
      unique case (op)
        OP_DROP_ALL: begin
          valid_d = '0;
          dirty_d = '0;
        end
        OP_DROP_LINE: if (sel_ok) begin
          valid_d[sel_line] = 1'b0;
          dirty_d[sel_line] = 1'b0;
        end
        OP_CLEAN: if (sel_ok && valid_q[sel_line] && dirty_q[sel_line]) begin
          wb_start          = 1'b1;
          dirty_d[sel_line] = 1'b0;
        end
        OP_CLEAN_DROP: if (sel_ok) begin
          wb_start          = valid_q[sel_line] && dirty_q[sel_line];
          valid_d[sel_line] = 1'b0;
          dirty_d[sel_line] = 1'b0;
        end
        default: ;
      endcase
    end else if (cmd_fire && cmd_read) begin
      rd_valid_d = 1'b1;
      if (op == OP_SCAN || op == OP_SCAN_DROP) begin
        rd_data_d[STATUS_DIRTY_BIT] = scan_found;
        if (scan_found) begin
          wb_start          = 1'b1;
          wb_line           = scan_idx;
          dirty_d[scan_idx] = 1'b0;
        end else if (op == OP_SCAN_DROP) begin
          valid_d = '0;
        end
      end
    end
    if (fill_wr_en) begin
      valid_d[fill_line] = 1'b1;
      dirty_d[fill_line] = fill_dirty;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      valid_q  <= '0;
      dirty_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      valid_q  <= valid_d;
      dirty_q  <= dirty_d;
      rd_valid <= rd_valid_d;
      if (rd_valid_d) rd_data <= rd_data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wr_en) begin
      tag_q[fill_line]  <= fill_tag;
      data_q[fill_line] <= fill_data;
    end
  end

  // write-back port
  logic [ADDR_W-1:0] wb_start_addr;
  assign wb_start_addr = {tag_q[wb_line], wb_line[LINE_W-1 -: SET_W], OFF_W'(0)};

  dcm_wb_port #(.ADDR_W(ADDR_W), .DATA_W(LINE_B)) u_wb (
    .clk(clk), .rst_n(rst_i_n), .start(wb_start), .start_addr(wb_start_addr),
    .start_data(data_q[wb_line]), .ack(wb_ack),
    .req(wb_req), .addr(wb_addr), .data(wb_data));

  // R2
  drop_all_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_fire && !cmd_read && cmd_op == 3'd0 && !fill_en) |=> (valid_q == '0 && !wb_req));

  // R7
  wb_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(wb_req) |-> $past(cmd_fire));

  // R10
  rd_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |-> ((rd_data & 32'hBFFF_FFFF) == 32'h0));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid |-> $past(cmd_fire && cmd_read));

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(p_match) && $onehot0(c_match));
endmodule

// File: tb/dcache_maint_test.sv
module dcache_maint_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_read, cmd_by_addr;
  logic [2:0]   cmd_op;
  logic [3:0]   cmd_set;
  logic [1:0]   cmd_way;
  logic [31:0]  cmd_addr;
  logic         cmd_ready, rd_valid, wb_req;
  logic [31:0]  rd_data, wb_addr;
  logic [255:0] wb_data;
  logic         wb_ack;
  logic         fill_en, fill_dirty;
  logic [3:0]   fill_set;
  logic [1:0]   fill_way;
  logic [22:0]  fill_tag;
  logic [255:0] fill_data;
  logic [31:0]  probe_addr;
  logic         probe_hit, probe_dirty;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dcache_maint uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_op(cmd_op), .cmd_by_addr(cmd_by_addr),
    .cmd_set(cmd_set), .cmd_way(cmd_way), .cmd_addr(cmd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_ack(wb_ack), .fill_en(fill_en), .fill_set(fill_set),
    .fill_way(fill_way), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .fill_data(fill_data), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_dirty(probe_dirty));

  function automatic logic [255:0] pat(input logic [22:0] t, input logic [3:0] s, input logic [1:0] w);
    logic [255:0] d;
    for (int i = 0; i < 8; i++)
      d[i*32 +: 32] = {i[3:0], s, w, t[21:0]} ^ 32'h5A5A_0000;
    return d;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [22:0] t, input logic [3:0] s);
    return {t, s, 5'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [3:0] s, input logic [1:0] w, input logic [22:0] t, input logic d);
    fill_set = s; fill_way = w; fill_tag = t; fill_dirty = d; fill_data = pat(t, s, w);
    fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic cmd(input logic rd, input logic [2:0] op, input logic ba,
                     input logic [3:0] s, input logic [1:0] w, input logic [31:0] a);
    cmd_read = rd; cmd_op = op; cmd_by_addr = ba; cmd_set = s; cmd_way = w; cmd_addr = a;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_wb(input string req, input logic [22:0] t, input logic [3:0] s, input logic [1:0] w);
    chk(req, "wb_req", wb_req, 1'b1);
    chk(req, "wb_addr", wb_addr, mk_addr(t, s));
    chk(req, "wb_data", wb_data, pat(t, s, w));
    chk("R7", "cmd_ready busy", cmd_ready, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7", "wb_req held", wb_req, 1'b1);
    chk("R7", "wb_addr stable", wb_addr, mk_addr(t, s));
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    chk("R7", "wb_req dropped", wb_req, 1'b0);
    chk("R7", "cmd_ready back", cmd_ready, 1'b1);
  endtask

  task automatic probe(input string req, input logic [22:0] t, input logic [3:0] s,
                       input logic eh, input logic ed);
    probe_addr = mk_addr(t, s) | 32'h14;
    #1;
    chk(req, "probe_hit", probe_hit, eh);
    chk(req, "probe_dirty", probe_dirty, ed);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "cmd_ready", cmd_ready, 1'b1);
    chk("R1", "wb_req", wb_req, 1'b0);
    chk("R1", "rd_valid", rd_valid, 1'b0);
    probe("R1", 23'h0, 4'd0, 1'b0, 1'b0);
  endtask

  task automatic t_drop_all;
    fill(4'd1, 2'd0, 23'h111, 1'b1);
    fill(4'd7, 2'd3, 23'h222, 1'b0);
    fill(4'd15, 2'd2, 23'h333, 1'b1);
    probe("R2", 23'h111, 4'd1, 1'b1, 1'b1);
    cmd(1'b0, 3'd0, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R2", "no wb", wb_req, 1'b0);
    probe("R2", 23'h111, 4'd1, 1'b0, 1'b0);
    probe("R2", 23'h222, 4'd7, 1'b0, 1'b0);
    probe("R2", 23'h333, 4'd15, 1'b0, 1'b0);
  endtask

  task automatic t_drop_line;
    fill(4'd2, 2'd0, 23'h40, 1'b1);
    fill(4'd2, 2'd1, 23'h41, 1'b1);
    cmd(1'b0, 3'd1, 1'b0, 4'd2, 2'd1, 32'h0);
    chk("R3", "no wb", wb_req, 1'b0);
    probe("R3", 23'h41, 4'd2, 1'b0, 1'b0);
    probe("R3", 23'h40, 4'd2, 1'b1, 1'b1);
  endtask

  task automatic t_clean;
    fill(4'd9, 2'd2, 23'h7ABCD, 1'b1);
    cmd(1'b0, 3'd2, 1'b0, 4'd9, 2'd2, 32'h0);
    expect_wb("R4", 23'h7ABCD, 4'd9, 2'd2);
    probe("R4", 23'h7ABCD, 4'd9, 1'b1, 1'b0);
    cmd(1'b0, 3'd2, 1'b0, 4'd9, 2'd2, 32'h0);
    chk("R4", "clean line no wb", wb_req, 1'b0);
    cmd(1'b0, 3'd2, 1'b0, 4'd9, 2'd0, 32'h0);
    chk("R4", "invalid line no wb", wb_req, 1'b0);
  endtask

  task automatic t_clean_drop;
    fill(4'd5, 2'd3, 23'h55, 1'b1);
    cmd(1'b0, 3'd3, 1'b1, 4'd0, 2'd0, mk_addr(23'h55, 4'd5) | 32'h8);
    expect_wb("R5", 23'h55, 4'd5, 2'd3);
    probe("R5", 23'h55, 4'd5, 1'b0, 1'b0);
    fill(4'd6, 2'd1, 23'h66, 1'b0);
    cmd(1'b0, 3'd3, 1'b0, 4'd6, 2'd1, 32'h0);
    chk("R5", "clean line no wb", wb_req, 1'b0);
    probe("R5", 23'h66, 4'd6, 1'b0, 1'b0);
  endtask

  task automatic t_by_addr;
    fill(4'd11, 2'd1, 23'h1234, 1'b1);
    cmd(1'b0, 3'd2, 1'b1, 4'd0, 2'd0, mk_addr(23'h1235, 4'd11));
    chk("R6", "miss no wb", wb_req, 1'b0);
    probe("R6", 23'h1234, 4'd11, 1'b1, 1'b1);
    cmd(1'b0, 3'd1, 1'b1, 4'd0, 2'd0, mk_addr(23'h1235, 4'd11));
    probe("R6", 23'h1234, 4'd11, 1'b1, 1'b1);
    cmd(1'b0, 3'd2, 1'b1, 4'd0, 2'd0, mk_addr(23'h1234, 4'd11));
    expect_wb("R6", 23'h1234, 4'd11, 2'd1);
    probe("R6", 23'h1234, 4'd11, 1'b1, 1'b0);
    cmd(1'b0, 3'd1, 1'b1, 4'd0, 2'd0, mk_addr(23'h1234, 4'd11));
    chk("R6", "drop by addr no wb", wb_req, 1'b0);
    probe("R6", 23'h1234, 4'd11, 1'b0, 1'b0);
  endtask

  task automatic t_scan;
    cmd(1'b0, 3'd0, 1'b0, 4'd0, 2'd0, 32'h0);
    fill(4'd1, 2'd2, 23'hA1, 1'b1);
    fill(4'd0, 2'd3, 23'hA0, 1'b1);
    fill(4'd0, 2'd0, 23'hB0, 1'b0);
    cmd(1'b1, 3'd4, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8", "rd_valid", rd_valid, 1'b1);
    chk("R8", "status dirty", rd_data, 32'h4000_0000);
    expect_wb("R8", 23'hA0, 4'd0, 2'd3);
    chk("R10", "rd_valid one cycle", rd_valid, 1'b0);
    cmd(1'b1, 3'd4, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8", "status dirty 2", rd_data, 32'h4000_0000);
    expect_wb("R8", 23'hA1, 4'd1, 2'd2);
    cmd(1'b1, 3'd4, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8", "status clean", rd_data, 32'h0);
    chk("R8", "no wb when clean", wb_req, 1'b0);
    probe("R8", 23'hA1, 4'd1, 1'b1, 1'b0);
    probe("R8", 23'hB0, 4'd0, 1'b1, 1'b0);
  endtask

  task automatic t_scan_drop;
    fill(4'd12, 2'd1, 23'hC1, 1'b1);
    cmd(1'b1, 3'd5, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R9", "status dirty", rd_data, 32'h4000_0000);
    expect_wb("R9", 23'hC1, 4'd12, 2'd1);
    probe("R9", 23'hC1, 4'd12, 1'b1, 1'b0);
    cmd(1'b1, 3'd5, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R9", "status clean", rd_data, 32'h0);
    chk("R9", "no wb", wb_req, 1'b0);
    probe("R9", 23'hC1, 4'd12, 1'b0, 1'b0);
    probe("R9", 23'hA1, 4'd1, 1'b0, 1'b0);
  endtask

  task automatic t_reserved;
    fill(4'd3, 2'd2, 23'hD3, 1'b1);
    cmd(1'b1, 3'd2, 1'b0, 4'd3, 2'd2, 32'h0);
    chk("R10", "rd_valid", rd_valid, 1'b1);
    chk("R10", "reserved read zero", rd_data, 32'h0);
    chk("R10", "reserved read no wb", wb_req, 1'b0);
    cmd(1'b0, 3'd4, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R10", "write scan rd_valid", rd_valid, 1'b0);
    chk("R10", "write scan no wb", wb_req, 1'b0);
    cmd(1'b0, 3'd5, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R10", "write scan-drop no wb", wb_req, 1'b0);
    probe("R10", 23'hD3, 4'd3, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_op = '0; cmd_by_addr = 1'b0;
    cmd_set = '0; cmd_way = '0; cmd_addr = '0; wb_ack = 1'b0; fill_en = 1'b0;
    fill_set = '0; fill_way = '0; fill_tag = '0; fill_dirty = 1'b0; fill_data = '0;
    probe_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_drop_all;
    t_drop_line;
    t_clean;
    t_clean_drop;
    t_by_addr;
    t_scan;
    t_scan_drop;
    t_reserved;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule